// File: doc/BRIEF.md
# AXI handshake stability checker

A passive observer for the five channels of an AXI4 memory-mapped link. It watches the write address, write data, write response, read address and read data channels and reports two kinds of handshake fault. The first kind is a payload field that changes while a transfer is stalled. The second is a VALID that is withdrawn before its READY arrives. It drives nothing on the link. Its outputs are meant to feed a logic analyser's trigger logic or an error-capture register.

For each channel the checker keeps one cycle of history: VALID, READY and the whole payload. A rule applies in a cycle only when that history shows a stall, meaning VALID was high and READY was low. Every payload field has its own error bit, and every channel has one bit for a withdrawn VALID. These bits are registered once and form a 39-bit flag vector.

The flags fall into two groups. The hold group covers payload changes and the drop group covers withdrawn VALIDs. Each group has an enable input and one registered trigger, which is the OR of its flags. The raw flag vector can be brought out or tied to zero with the `SHOW_FLAGS` parameter.

Top module: `axhs_checker`

## Requirements
- R1: When the previous cycle had aw_valid=1 and aw_ready=0, a change in any write-address field sets that field's flag. The flag bits are: addr 5, burst 6, cache 7, id 8, len 9, lock 10, prot 11, size 12, qos 13, region 14, user 15.
- R2: The same stall rule applies on the write data channel, with flags data 16, last 17, strb 18, user 19. It applies on the write response channel with flags id 20, resp 21, user 22.
- R3: The same stall rule applies on the read address channel, with flags addr 23, burst 24, cache 25, id 26, len 27, lock 28, prot 29, size 30, qos 31, region 32, user 33. It applies on the read data channel with flags data 34, id 35, last 36, resp 37, user 38.
- R4: When the previous cycle was stalled on a channel and that channel's VALID is now low, the channel's drop flag is set. The drop flags are bit 0 for write address, 1 for write data, 2 for write response, 3 for read address and 4 for read data.
- R5: No flag is raised for payload changes after a cycle where VALID was low, or where VALID and READY were both high.
- R6: A flag appears on `flags` in the cycle after the offending cycle and lasts one cycle unless the fault repeats.
- R7: `trig_hold` is the OR of flags 5 to 38 and `trig_drop` is the OR of flags 0 to 4. Each trigger is high two cycles after the offending cycle, which is within the 3-cycle bound.
- R8: While a group's enable is low during the cycle its flags are visible, that group's trigger stays low, and `flags` still shows the bits.
- R9: An active-low reset clears all history and outputs. No flag is raised for the first clock after reset is released, even if the link was stalled across the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the observed link |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_hold | input | 1 | Enable for the payload-stability trigger group |
| en_drop | input | 1 | Enable for the valid-withdrawal trigger group |
| aw_valid | input | 1 | Write address VALID |
| aw_ready | input | 1 | Write address READY |
| aw_addr | input | ADDR_W | Write address |
| aw_burst | input | 2 | Write burst type |
| aw_cache | input | 4 | Write cache attributes |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | 8 | Write burst length |
| aw_lock | input | 1 | Write lock type |
| aw_prot | input | 3 | Write protection type |
| aw_size | input | 3 | Write beat size |
| aw_qos | input | 4 | Write quality of service |
| aw_region | input | 4 | Write region selector |
| aw_user | input | USER_W | Write address user bits |
| w_valid | input | 1 | Write data VALID |
| w_ready | input | 1 | Write data READY |
| w_data | input | DATA_W | Write data |
| w_last | input | 1 | Last write beat |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_user | input | USER_W | Write data user bits |
| b_valid | input | 1 | Write response VALID |
| b_ready | input | 1 | Write response READY |
| b_id | input | ID_W | Write response ID |
| b_resp | input | 2 | Write response code |
| b_user | input | USER_W | Write response user bits |
| ar_valid | input | 1 | Read address VALID |
| ar_ready | input | 1 | Read address READY |
| ar_addr | input | ADDR_W | Read address |
| ar_burst | input | 2 | Read burst type |
| ar_cache | input | 4 | Read cache attributes |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | 8 | Read burst length |
| ar_lock | input | 1 | Read lock type |
| ar_prot | input | 3 | Read protection type |
| ar_size | input | 3 | Read beat size |
| ar_qos | input | 4 | Read quality of service |
| ar_region | input | 4 | Read region selector |
| ar_user | input | USER_W | Read address user bits |
| r_valid | input | 1 | Read data VALID |
| r_ready | input | 1 | Read data READY |
| r_data | input | DATA_W | Read data |
| r_id | input | ID_W | Read data ID |
| r_last | input | 1 | Last read beat |
| r_resp | input | 2 | Read response code |
| r_user | input | USER_W | Read data user bits |
| trig_hold | output | 1 | Registered OR of the payload-stability flags, gated by en_hold |
| trig_drop | output | 1 | Registered OR of the valid-withdrawal flags, gated by en_drop |
| flags | output | 39 | Per-rule error pulses (zero when SHOW_FLAGS=0) |

## Verification
Each of the 34 payload fields is toggled alone on a stalled channel. A one-hot flag at the listed bit shows that the field boundaries and the flag order are right and that no field leaks into its neighbour. The same toggles are repeated after an accepted beat and with VALID low, where no flag may rise, which separates a stall from plain traffic. Each channel's VALID is also withdrawn during a stall. A reset is applied in the middle of a stall, and a group enable is dropped, to show that history is cleared and that gating affects only the trigger. A long stretch of random VALID, READY, enable and field activity is then compared every clock against a behavioural model of the rules.

// File: rtl/axhs_pkg.sv
package axhs_pkg;
  // widest payload the mask helper supports
  localparam int PMAX = 1024;
  localparam int NCHAN = 5;
  // flag vector layout: drop flags first, then payload flags
  localparam int DROP_BASE = 0;
  localparam int HOLD_BASE = NCHAN;

  // mask of `wid` ones starting at bit `lo`
  function automatic logic [PMAX-1:0] span_mask(input int lo, input int wid);
    logic [PMAX-1:0] one;
    one = PMAX'(1);
    return ((one << wid) - one) << lo;
  endfunction
endpackage

// File: rtl/axhs_chan_watch.sv
module axhs_chan_watch #(
  parameter int NF = 1,
  parameter int W = 1,
  parameter logic [NF-1:0][15:0] FW = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          valid,
  input  logic          ready,
  input  logic [W-1:0]  payload,
  output logic [NF-1:0] hold_err,
  output logic          drop_err
);
  // lowest bit of field k inside the payload
  function automatic int lo_of(input int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += int'(FW[j]);
    return s;
  endfunction

  logic         v_q, r_q;
  logic [W-1:0] p_q;
  logic         stall_seen;
  logic [NF-1:0] hold_hit;
  logic         drop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      r_q <= 1'b0;
      p_q <= '0;
    end else begin
      v_q <= valid;
      r_q <= ready;
      p_q <= payload;
    end
  end

  assign stall_seen = arm & v_q & ~r_q;
  assign drop_hit   = stall_seen & ~valid;

  for (genvar k = 0; k < NF; k++) begin : g_field
    localparam int LO = lo_of(k);
    localparam logic [W-1:0] MASK = W'(axhs_pkg::span_mask(LO, int'(FW[k])));
    assign hold_hit[k] = stall_seen & (|((payload ^ p_q) & MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_err <= '0;
      drop_err <= 1'b0;
    end else begin
      hold_err <= hold_hit;
      drop_err <= drop_hit;
    end
  end

  // R4: a drop flag needs a stall two cycles back and a low VALID one cycle back
  p_drop_after_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> ($past(valid, 2) && !$past(ready, 2) && !$past(valid)));

  // R1, R2, R3: a field flag needs a stall two cycles back
  p_hold_after_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|hold_err) |-> ($past(valid, 2) && !$past(ready, 2)));

  // R5: an accepted beat never yields a flag one cycle later
  p_accept_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> ##1 (hold_err == '0 && !drop_err));
endmodule

// File: rtl/axhs_group_or.sv
module axhs_group_or #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] flags,
  output logic         trig
);
  logic any_flag;
  assign any_flag = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= en & any_flag;
  end

  // R7: trigger follows an enabled flag and has no other source
  p_trig_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(en) && $past(|flags)));
  p_trig_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (|flags)) |=> trig);
  // R8: a disabled group stays silent
  p_trig_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !trig);
endmodule

// File: rtl/axhs_checker.sv
module axhs_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W = 4,
  parameter int USER_W = 1,
  parameter bit SHOW_FLAGS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_hold,
  input  logic                en_drop,
  input  logic                aw_valid,
  input  logic                aw_ready,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [1:0]          aw_burst,
  input  logic [3:0]          aw_cache,
  input  logic [ID_W-1:0]     aw_id,
  input  logic [7:0]          aw_len,
  input  logic                aw_lock,
  input  logic [2:0]          aw_prot,
  input  logic [2:0]          aw_size,
  input  logic [3:0]          aw_qos,
  input  logic [3:0]          aw_region,
  input  logic [USER_W-1:0]   aw_user,
  input  logic                w_valid,
  input  logic                w_ready,
  input  logic [DATA_W-1:0]   w_data,
  input  logic                w_last,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic [USER_W-1:0]   w_user,
  input  logic                b_valid,
  input  logic                b_ready,
  input  logic [ID_W-1:0]     b_id,
  input  logic [1:0]          b_resp,
  input  logic [USER_W-1:0]   b_user,
  input  logic                ar_valid,
  input  logic                ar_ready,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic [1:0]          ar_burst,
  input  logic [3:0]          ar_cache,
  input  logic [ID_W-1:0]     ar_id,
  input  logic [7:0]          ar_len,
  input  logic                ar_lock,
  input  logic [2:0]          ar_prot,
  input  logic [2:0]          ar_size,
  input  logic [3:0]          ar_qos,
  input  logic [3:0]          ar_region,
  input  logic [USER_W-1:0]   ar_user,
  input  logic                r_valid,
  input  logic                r_ready,
  input  logic [DATA_W-1:0]   r_data,
  input  logic [ID_W-1:0]     r_id,
  input  logic                r_last,
  input  logic [1:0]          r_resp,
  input  logic [USER_W-1:0]   r_user,
  output logic                trig_hold,
  output logic                trig_drop,
  output logic [38:0]         flags
);
  import axhs_pkg::*;

  localparam int STRB_W = DATA_W / 8;
  localparam int AX_W   = ADDR_W + 2 + 4 + ID_W + 8 + 1 + 3 + 3 + 4 + 4 + USER_W;
  localparam int WD_W   = DATA_W + 1 + STRB_W + USER_W;
  localparam int BR_W   = ID_W + 2 + USER_W;
  localparam int RD_W   = DATA_W + ID_W + 1 + 2 + USER_W;
  localparam int AX_NF = 11, WD_NF = 4, BR_NF = 3, RD_NF = 5;
  localparam int NHOLD = 2 * AX_NF + WD_NF + BR_NF + RD_NF;
  localparam int NFLAG = NCHAN + NHOLD;

  // field widths, highest field first so field 0 lands at the payload LSB
  localparam logic [AX_NF-1:0][15:0] AX_FW = {16'(USER_W), 16'd4, 16'd4, 16'd3, 16'd3,
    16'd1, 16'd8, 16'(ID_W), 16'd4, 16'd2, 16'(ADDR_W)};
  localparam logic [WD_NF-1:0][15:0] WD_FW = {16'(USER_W), 16'(STRB_W), 16'd1, 16'(DATA_W)};
  localparam logic [BR_NF-1:0][15:0] BR_FW = {16'(USER_W), 16'd2, 16'(ID_W)};
  localparam logic [RD_NF-1:0][15:0] RD_FW = {16'(USER_W), 16'd2, 16'd1, 16'(ID_W), 16'(DATA_W)};

  logic armed;
  logic [AX_NF-1:0] aw_hold, ar_hold;
  logic [WD_NF-1:0] w_hold;
  logic [BR_NF-1:0] b_hold;
  logic [RD_NF-1:0] r_hold;
  logic [NCHAN-1:0] drop_vec;
  logic [NFLAG-1:0] flags_raw;

  // the first edge after reset release only loads history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  axhs_chan_watch #(.NF(AX_NF), .W(AX_W), .FW(AX_FW)) u_aw (
    .clk(clk), .rst_n(rst_n), .arm(armed), .valid(aw_valid), .ready(aw_ready),
    .payload({aw_user, aw_region, aw_qos, aw_size, aw_prot, aw_lock, aw_len,
              aw_id, aw_cache, aw_burst, aw_addr}),
    .hold_err(aw_hold), .drop_err(drop_vec[0]));

  axhs_chan_watch #(.NF(WD_NF), .W(WD_W), .FW(WD_FW)) u_w (
    .clk(clk), .rst_n(rst_n), .arm(armed), .valid(w_valid), .ready(w_ready),
    .payload({w_user, w_strb, w_last, w_data}),
    .hold_err(w_hold), .drop_err(drop_vec[1]));

  axhs_chan_watch #(.NF(BR_NF), .W(BR_W), .FW(BR_FW)) u_b (
    .clk(clk), .rst_n(rst_n), .arm(armed), .valid(b_valid), .ready(b_ready),
    .payload({b_user, b_resp, b_id}),
    .hold_err(b_hold), .drop_err(drop_vec[2]));

  axhs_chan_watch #(.NF(AX_NF), .W(AX_W), .FW(AX_FW)) u_ar (
    .clk(clk), .rst_n(rst_n), .arm(armed), .valid(ar_valid), .ready(ar_ready),
    .payload({ar_user, ar_region, ar_qos, ar_size, ar_prot, ar_lock, ar_len,
              ar_id, ar_cache, ar_burst, ar_addr}),
    .hold_err(ar_hold), .drop_err(drop_vec[3]));

  axhs_chan_watch #(.NF(RD_NF), .W(RD_W), .FW(RD_FW)) u_r (
    .clk(clk), .rst_n(rst_n), .arm(armed), .valid(r_valid), .ready(r_ready),
    .payload({r_user, r_resp, r_last, r_id, r_data}),
    .hold_err(r_hold), .drop_err(drop_vec[4]));

  assign flags_raw = {r_hold, ar_hold, b_hold, w_hold, aw_hold, drop_vec};

  axhs_group_or #(.N(NHOLD)) u_grp_hold (
    .clk(clk), .rst_n(rst_n), .en(en_hold),
    .flags(flags_raw[NFLAG-1:HOLD_BASE]), .trig(trig_hold));

  axhs_group_or #(.N(NCHAN)) u_grp_drop (
    .clk(clk), .rst_n(rst_n), .en(en_drop),
    .flags(flags_raw[DROP_BASE+NCHAN-1:DROP_BASE]), .trig(trig_drop));

  if (SHOW_FLAGS) begin : g_show
    assign flags = flags_raw;
  end else begin : g_hide
    assign flags = '0;
  end

  // R9: nothing is flagged for the edge that first loads history
  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (flags_raw == '0));
  // R6: a write-address stall that ends in acceptance with steady payload gives no pulse
  p_steady_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && aw_valid && !aw_ready) ##1 (aw_valid && $stable(aw_addr)) |=> !flags_raw[5]);
endmodule

// File: tb/sim_axhs_checker.sv
`timescale 1ns/1ps
module sim_axhs_checker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en_hold, en_drop;
  logic [4:0] vld, rdy;
  logic [31:0] aw_addr, ar_addr, w_data, r_data;
  logic [1:0] aw_burst, ar_burst, b_resp, r_resp;
  logic [3:0] aw_cache, ar_cache, aw_id, ar_id, b_id, r_id, w_strb;
  logic [3:0] aw_qos, ar_qos, aw_region, ar_region;
  logic [7:0] aw_len, ar_len;
  logic aw_lock, ar_lock, w_last, r_last;
  logic [2:0] aw_prot, ar_prot, aw_size, ar_size;
  logic aw_user, w_user, b_user, ar_user, r_user;
  logic trig_hold, trig_drop;
  logic [38:0] flags;

  axhs_checker u0 (
    .clk(clk), .rst_n(rst_n), .en_hold(en_hold), .en_drop(en_drop),
    .aw_valid(vld[0]), .aw_ready(rdy[0]), .aw_addr(aw_addr), .aw_burst(aw_burst),
    .aw_cache(aw_cache), .aw_id(aw_id), .aw_len(aw_len), .aw_lock(aw_lock),
    .aw_prot(aw_prot), .aw_size(aw_size), .aw_qos(aw_qos), .aw_region(aw_region),
    .aw_user(aw_user),
    .w_valid(vld[1]), .w_ready(rdy[1]), .w_data(w_data), .w_last(w_last),
    .w_strb(w_strb), .w_user(w_user),
    .b_valid(vld[2]), .b_ready(rdy[2]), .b_id(b_id), .b_resp(b_resp), .b_user(b_user),
    .ar_valid(vld[3]), .ar_ready(rdy[3]), .ar_addr(ar_addr), .ar_burst(ar_burst),
    .ar_cache(ar_cache), .ar_id(ar_id), .ar_len(ar_len), .ar_lock(ar_lock),
    .ar_prot(ar_prot), .ar_size(ar_size), .ar_qos(ar_qos), .ar_region(ar_region),
    .ar_user(ar_user),
    .r_valid(vld[4]), .r_ready(rdy[4]), .r_data(r_data), .r_id(r_id), .r_last(r_last),
    .r_resp(r_resp), .r_user(r_user),
    .trig_hold(trig_hold), .trig_drop(trig_drop), .flags(flags));

  int checks = 0, errors = 0;
  string cur_req = "R9";

  typedef logic [63:0] fv_t [34];

  function automatic int chan_of(input int k);
    if (k < 11) return 0;
    if (k < 15) return 1;
    if (k < 18) return 2;
    if (k < 29) return 3;
    return 4;
  endfunction

  // field values in flag order (flag bit = 5 + index)
  task automatic snap(output fv_t f);
    f[0]=64'(aw_addr); f[1]=64'(aw_burst); f[2]=64'(aw_cache); f[3]=64'(aw_id);
    f[4]=64'(aw_len); f[5]=64'(aw_lock); f[6]=64'(aw_prot); f[7]=64'(aw_size);
    f[8]=64'(aw_qos); f[9]=64'(aw_region); f[10]=64'(aw_user);
    f[11]=64'(w_data); f[12]=64'(w_last); f[13]=64'(w_strb); f[14]=64'(w_user);
    f[15]=64'(b_id); f[16]=64'(b_resp); f[17]=64'(b_user);
    f[18]=64'(ar_addr); f[19]=64'(ar_burst); f[20]=64'(ar_cache); f[21]=64'(ar_id);
    f[22]=64'(ar_len); f[23]=64'(ar_lock); f[24]=64'(ar_prot); f[25]=64'(ar_size);
    f[26]=64'(ar_qos); f[27]=64'(ar_region); f[28]=64'(ar_user);
    f[29]=64'(r_data); f[30]=64'(r_id); f[31]=64'(r_last); f[32]=64'(r_resp);
    f[33]=64'(r_user);
  endtask

  task automatic flip(input int k);
    case (k)
      0: aw_addr ^= 32'h8000_0001; 1: aw_burst ^= 2'b01; 2: aw_cache ^= 4'h8;
      3: aw_id ^= 4'h1; 4: aw_len ^= 8'h80; 5: aw_lock = ~aw_lock; 6: aw_prot ^= 3'h4;
      7: aw_size ^= 3'h1; 8: aw_qos ^= 4'h8; 9: aw_region ^= 4'h1; 10: aw_user = ~aw_user;
      11: w_data ^= 32'h0001_0000; 12: w_last = ~w_last; 13: w_strb ^= 4'h8; 14: w_user = ~w_user;
      15: b_id ^= 4'h8; 16: b_resp ^= 2'b10; 17: b_user = ~b_user;
      18: ar_addr ^= 32'h0000_0100; 19: ar_burst ^= 2'b10; 20: ar_cache ^= 4'h1;
      21: ar_id ^= 4'h8; 22: ar_len ^= 8'h01; 23: ar_lock = ~ar_lock; 24: ar_prot ^= 3'h1;
      25: ar_size ^= 3'h4; 26: ar_qos ^= 4'h1; 27: ar_region ^= 4'h8; 28: ar_user = ~ar_user;
      29: r_data ^= 32'h8000_0000; 30: r_id ^= 4'h1; 31: r_last = ~r_last; 32: r_resp ^= 2'b01;
      default: r_user = ~r_user;
    endcase
  endtask

  // behavioural reference of the rules, updated on every clock
  fv_t cur_f, prev_f;
  logic [4:0] pv, pr;
  logic armed_m;
  logic [38:0] exp_flags, nf;
  logic exp_th, exp_td;

  always @(posedge clk) begin
    if (!rst_n) begin
      pv = '0; pr = '0; armed_m = 1'b0; exp_flags = '0; exp_th = 1'b0; exp_td = 1'b0;
    end else begin
      snap(cur_f);
      nf = '0;
      for (int c = 0; c < 5; c++)
        if (armed_m && pv[c] && !pr[c] && !vld[c]) nf[c] = 1'b1;
      for (int k = 0; k < 34; k++)
        if (armed_m && pv[chan_of(k)] && !pr[chan_of(k)] && cur_f[k] != prev_f[k])
          nf[5+k] = 1'b1;
      exp_th = en_hold && (exp_flags[38:5] != '0);
      exp_td = en_drop && (exp_flags[4:0] != '0);
      exp_flags = nf;
      prev_f = cur_f;
      pv = vld; pr = rdy; armed_m = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, 64'(flags), 64'(exp_flags));
    chk(cur_req, 64'(trig_hold), 64'(exp_th));
    chk(cur_req, 64'(trig_drop), 64'(exp_td));
  endtask

  task automatic idle();
    vld = '0; rdy = '0; tick(); tick();
  endtask

  initial begin
    rst_n = 1'b0; en_hold = 1'b1; en_drop = 1'b1; vld = '0; rdy = '0;
    aw_addr = 0; ar_addr = 0; w_data = 0; r_data = 0; aw_burst = 0; ar_burst = 0;
    b_resp = 0; r_resp = 0; aw_cache = 0; ar_cache = 0; aw_id = 0; ar_id = 0; b_id = 0;
    r_id = 0; w_strb = 0; aw_qos = 0; ar_qos = 0; aw_region = 0; ar_region = 0;
    aw_len = 0; ar_len = 0; aw_lock = 0; ar_lock = 0; w_last = 0; r_last = 0;
    aw_prot = 0; ar_prot = 0; aw_size = 0; ar_size = 0;
    aw_user = 0; w_user = 0; b_user = 0; ar_user = 0; r_user = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset flags", 64'(flags), 64'd0);
    chk("R9 reset trig", 64'({trig_hold, trig_drop}), 64'd0);
    rst_n = 1'b1;
    tick();

    // R1, R2, R3, R6, R7: each field alone on a stalled channel
    for (int k = 0; k < 34; k++) begin
      int c;
      c = chan_of(k);
      cur_req = (c == 0) ? "R1" : (c < 3) ? "R2" : "R3";
      vld[c] = 1'b1; rdy[c] = 1'b0; tick();
      flip(k); tick();
      chk(cur_req, 64'(flags), 64'd1 << (5 + k));
      tick();
      chk("R6 pulse", 64'(flags), 64'd0);
      chk("R7 trig_hold", 64'(trig_hold), 64'd1);
      rdy[c] = 1'b1; tick();
      idle();
    end

    // R5: changes after accepted beats or with VALID low stay silent
    cur_req = "R5";
    vld = '1; rdy = '1;
    for (int n = 0; n < 3; n++) begin
      for (int k = 0; k < 34; k++) flip(k);
      tick();
    end
    vld = '0; rdy = '0;
    for (int n = 0; n < 3; n++) begin
      for (int k = 0; k < 34; k++) flip(k);
      tick();
      chk("R5 idle", 64'(flags), 64'd0);
    end

    // R4: withdrawn VALID on every channel
    for (int c = 0; c < 5; c++) begin
      cur_req = "R4";
      vld[c] = 1'b1; rdy[c] = 1'b0; tick();
      vld[c] = 1'b0; tick();
      chk("R4", 64'(flags), 64'd1 << c);
      tick();
      chk("R7 trig_drop", 64'(trig_drop), 64'd1);
      idle();
    end

    // R8: disabled group keeps its trigger low while flags show
    cur_req = "R8";
    en_hold = 1'b0; en_drop = 1'b0;
    vld[3] = 1'b1; tick();
    flip(18); tick();
    chk("R8 flag", 64'(flags), 64'd1 << 23);
    vld[3] = 1'b0; tick();
    chk("R8 trig", 64'({trig_hold, trig_drop}), 64'd0);
    tick();
    chk("R8 drop trig", 64'(trig_drop), 64'd0);
    en_hold = 1'b1; en_drop = 1'b1;
    idle();

    // R9: reset in the middle of a stall, payload change in the first cycle after
    cur_req = "R9";
    vld[0] = 1'b1; tick(); tick();
    rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1; flip(0); tick();
    chk("R9 first edge", 64'(flags), 64'd0);
    tick();
    chk("R9 second edge", 64'(flags), 64'd0);
    idle();

    // R7: random traffic against the model
    cur_req = "R7";
    for (int n = 0; n < 3000; n++) begin
      vld = 5'($urandom); rdy = 5'($urandom);
      en_hold = ($urandom % 4) != 0; en_drop = ($urandom % 4) != 0;
      if ($urandom % 2) flip($urandom % 34);
      if ($urandom % 3 == 0) flip($urandom % 34);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule